// File: doc/BRIEF.md
# Halt Mode Standby Controller

This block sequences standby for a small 8-bit microcontroller. Software chooses one of four standby levels through a two-bit field in a memory-mapped control register. When the CPU reports that it has executed a HALT, the block gates clocks to match that level. The gated clocks are the CPU clock, the general peripheral clock, the clock of a designated group of I/O peripherals, and the oscillator enable.

The block leaves standby when a wake source arrives or when reset is asserted. A non-maskable interrupt, or a maskable interrupt while interrupts are enabled, tells the CPU to take the interrupt. A maskable interrupt while interrupts are disabled still wakes the core. In that case the CPU only continues after the HALT, and the request stays pending in the interrupt controller. Waking from the deepest level first allows a fixed oscillator settling time.

Top module: `standby_seq`

## Requirements
- R1: The mode field occupies bits 3:2 of the register. A write with `reg_sel` and `reg_wr` high updates only that field. `reg_rdata` returns the field at bits 3:2 and zero on every other bit. The encoding is 00 = RUN, 01 = STOP, 10 = IDLE1, 11 = IDLE2.
- R2: While reset is held and after it is released, the field reads 00, all four enables are 1, and `wake_pulse` and `take_irq` are 0.
- R3: RUN level: from the cycle after the `halt_req` edge, `cpu_clk_en` is 0 and the other three enables stay at 1.
- R4: IDLE1 level: from the cycle after the `halt_req` edge, `cpu_clk_en`, `per_clk_en` and `io_clk_en` are 0 and `osc_en` is 1.
- R5: IDLE2 level: from the cycle after the `halt_req` edge, `cpu_clk_en` and `per_clk_en` are 0, and `io_clk_en` and `osc_en` are 1.
- R6: STOP level: from the cycle after the `halt_req` edge, all four enables are 0.
- R7: Waking from RUN, IDLE1 or IDLE2 happens at the first edge that sees `nmi_req`, or `int_req` together with `int_en`. After that edge all enables are 1, `wake_pulse` is 1 for exactly one cycle, and `take_irq` is 1.
- R8: `int_req` with `int_en` low also ends standby with the same timing as R7. In that case `take_irq` is 0, meaning the CPU resumes after the HALT.
- R9: Waking from STOP first holds `osc_en` at 1 and the other enables at 0 for WARMUP cycles (default 16). Only then does the R7 or R8 resume occur.
- R10: Reset during any standby level restores all enables to 1 and the field to 00.
- R11: While halted with no wake source, the enables stay constant and `wake_pulse` stays 0, whatever `int_en` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 1 | Register selected by the address decoder |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data, mode field only |
| halt_req | input | 1 | CPU executed HALT (one-cycle pulse) |
| nmi_req | input | 1 | Non-maskable interrupt request |
| int_req | input | 1 | Maskable interrupt request |
| int_en | input | 1 | CPU interrupt-enable flag |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | General peripheral clock enable |
| io_clk_en | output | 1 | Designated I/O peripheral clock enable |
| osc_en | output | 1 | Oscillator enable |
| wake_pulse | output | 1 | One-cycle resume strobe to the CPU |
| take_irq | output | 1 | 1 = take interrupt, 0 = continue after HALT |

## Verification
The hardest case to reach is the STOP exit. The warm-up window must be observed for its full length, and the resume type must be the one decided at the wake edge. The bench therefore crosses every level with every wake source, including reset. Each wake source is raised for a single cycle only, so any late sampling shows up. Random rounds also hold the core halted for a random number of quiet cycles while toggling `int_en`, to confirm it does not wake early.

// File: rtl/standby_seq.sv
module standby_seq #(
  parameter int DW      = 8,
  parameter int FLD_LSB = 2,
  parameter int WARMUP  = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_sel,
  input  logic          reg_wr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          halt_req,
  input  logic          nmi_req,
  input  logic          int_req,
  input  logic          int_en,
  output logic          cpu_clk_en,
  output logic          per_clk_en,
  output logic          io_clk_en,
  output logic          osc_en,
  output logic          wake_pulse,
  output logic          take_irq
);
  localparam int CW = $clog2(WARMUP + 1);
  localparam logic [1:0] M_RUN = 2'b00, M_STOP = 2'b01, M_IDLE1 = 2'b10, M_IDLE2 = 2'b11;

  typedef enum logic [1:0] {S_ACT, S_HALT, S_WARM} st_t;

  st_t          st;
  logic [1:0]   fld, lvl;
  logic [CW-1:0] cnt;
  logic          wake, take_now;

  assign wake     = nmi_req | int_req;
  assign take_now = nmi_req | (int_req & int_en);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) fld <= M_RUN;
    else if (reg_sel && reg_wr) fld <= reg_wdata[FLD_LSB +: 2];

  always_comb begin
    reg_rdata = '0;
    reg_rdata[FLD_LSB +: 2] = fld;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_ACT;
      lvl <= M_RUN;
      cnt <= '0;
      wake_pulse <= 1'b0;
      take_irq <= 1'b0;
    end else begin
      wake_pulse <= 1'b0;
      case (st)
        S_ACT:
          if (halt_req) begin
            st  <= S_HALT;
            lvl <= fld;
          end
        S_HALT:
          if (wake) begin
            take_irq <= take_now;
            if (lvl == M_STOP) begin
              st  <= S_WARM;
              cnt <= '0;
            end else begin
              st <= S_ACT;
              wake_pulse <= 1'b1;
            end
          end
        S_WARM:
          if (cnt == CW'(WARMUP - 1)) begin
            st <= S_ACT;
            wake_pulse <= 1'b1;
          end else cnt <= cnt + 1'b1;
        default: st <= S_ACT;
      endcase
    end

  wire halted = (st == S_HALT);
  assign cpu_clk_en = (st == S_ACT);
  assign per_clk_en = cpu_clk_en | (halted & (lvl == M_RUN));
  assign io_clk_en  = cpu_clk_en | (halted & (lvl == M_RUN || lvl == M_IDLE2));
  assign osc_en     = cpu_clk_en | (st == S_WARM) | (halted & (lvl != M_STOP));

  a_r3_halt_stops_cpu: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_clk_en && halt_req) |=> !cpu_clk_en);
  a_r6_osc_off_gates_all: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_en |-> (!per_clk_en && !io_clk_en && !cpu_clk_en));
  a_r7_pulse_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |=> !wake_pulse);
  a_r7_nmi_takes: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_clk_en && osc_en && nmi_req && !(st == S_WARM)) |=> take_irq);
  a_r8_masked_resumes: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !nmi_req && int_req && !int_en) |=> !take_irq);
  a_r9_resume_with_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_clk_en) |-> wake_pulse);
  a_r11_quiet_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !nmi_req && !int_req) |=> ($stable(per_clk_en) && !cpu_clk_en && !wake_pulse));
endmodule

// File: tb/sim_standby_seq.sv
module sim_standby_seq;
  localparam int WARMUP = 16;
  logic clk = 0, rst_n = 0;
  logic reg_sel = 0, reg_wr = 0, halt_req = 0, nmi_req = 0, int_req = 0, int_en = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic cpu_clk_en, per_clk_en, io_clk_en, osc_en, wake_pulse, take_irq;
  int total = 0, bad = 0;

  standby_seq #(.DW(8), .FLD_LSB(2), .WARMUP(WARMUP)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .halt_req(halt_req), .nmi_req(nmi_req), .int_req(int_req),
    .int_en(int_en), .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .io_clk_en(io_clk_en),
    .osc_en(osc_en), .wake_pulse(wake_pulse), .take_irq(take_irq));

  always #10 clk = ~clk;

  initial begin
    #(20 * 200000);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  function automatic logic [3:0] gates_halted(input logic [1:0] m);
    case (m)
      2'b00: return 4'b0111;
      2'b10: return 4'b0001;
      2'b11: return 4'b0011;
      default: return 4'b0000;
    endcase
  endfunction

  function automatic string req_of(input logic [1:0] m);
    case (m)
      2'b00: return "R3";
      2'b10: return "R4";
      2'b11: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", r, act, exp);
    end
  endtask

  function automatic logic [3:0] gv();
    return {cpu_clk_en, per_clk_en, io_clk_en, osc_en};
  endfunction

  task automatic wr_mode(input logic [1:0] m);
    logic [7:0] d;
    d = 8'($urandom);
    d[3:2] = m;
    reg_sel = 1; reg_wr = 1; reg_wdata = d;
    @(negedge clk);
    reg_sel = 0; reg_wr = 0; reg_wdata = ~d;
    chk("R1", reg_rdata, {4'b0, m, 2'b0});
  endtask

  // src: 0 nmi, 1 int enabled, 2 int disabled, 3 reset
  task automatic round(input logic [1:0] m, input int src, input int quiet);
    wr_mode(m);
    halt_req = 1;
    @(negedge clk);
    halt_req = 0;
    chk(req_of(m), gv(), gates_halted(m));
    for (int i = 0; i < quiet; i++) begin
      int_en = 1'($urandom);
      reg_wdata = 8'($urandom);
      @(negedge clk);
      chk("R11", {wake_pulse, gv()}, {1'b0, gates_halted(m)});
    end
    if (src == 3) begin
      rst_n = 0;
      #3;
      chk("R10", {gv(), reg_rdata}, {4'hF, 8'h00});
      @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk("R10", {gv(), wake_pulse}, {4'hF, 1'b0});
      return;
    end
    nmi_req = (src == 0);
    int_req = (src != 0);
    int_en  = (src == 1);
    @(negedge clk);
    nmi_req = 0; int_req = 0; int_en = 0;
    if (m == 2'b01) begin
      for (int i = 0; i < WARMUP; i++) begin
        chk("R9", {gv(), wake_pulse}, {4'b0001, 1'b0});
        @(negedge clk);
      end
    end
    chk(src == 2 ? "R8" : "R7", {gv(), wake_pulse, take_irq}, {4'hF, 1'b1, src != 2});
    @(negedge clk);
    chk("R7", {wake_pulse, gv()}, {1'b0, 4'hF});
  endtask

  initial begin
    void'($urandom(32'd1234));
    #3;
    chk("R2", {gv(), wake_pulse, take_irq, reg_rdata}, {4'hF, 2'b00, 8'h00});
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R2", {gv(), wake_pulse, take_irq, reg_rdata}, {4'hF, 2'b00, 8'h00});
    wr_mode(2'b11); wr_mode(2'b01); wr_mode(2'b10); wr_mode(2'b00);
    reg_sel = 0; reg_wr = 1; reg_wdata = 8'hFF;
    @(negedge clk);
    reg_wr = 0;
    chk("R1", reg_rdata, 8'h00);
    for (int m = 0; m < 4; m++)
      for (int s = 0; s < 4; s++)
        round(2'(m), s, 1);
    for (int k = 0; k < 60; k++)
      round(2'($urandom), int'($urandom_range(0, 3)), int'($urandom_range(0, 6)));
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule